// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static RAM. It stores 36-bit words split into four byte lanes of nine bits, and it registers every synchronous input on the rising clock edge. Either of two address strobes starts an access. One strobe is meant for a processor and the other for a memory controller. After that, an internal two-bit burst counter produces the following addresses whenever the advance input is asserted. Reads are pipelined. The word for a newly strobed address appears on the third cycle, and each advanced word follows one cycle later, which gives a 3-1-1-1 burst.

Writes are self-timed. They are decoded from three controls:
- a global write that covers every lane,
- a byte-write enable,
- one strobe per lane.

The bidirectional data bus is split into separate ports: a write-data input, a read-data output, and a read-valid flag. The output enable gates the flag and the read data combinationally, so it does not wait for a clock edge. The burst order is fixed when the block is instantiated. It is either a linear count or an XOR-interleaved count within an aligned group of four words.

Top module: `sb_sram`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `rdata_vld` is 0 and `rdata` is all zeros.
- R2: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 are sampled on a strobe edge. A strobe sampled with any other combination performs no access and ends the current burst, so later advance cycles produce no access until the next selected strobe.
- R3: A read whose address is sampled with a strobe at clock edge k shows its word on `rdata` with `rdata_vld`=1 after edge k+2.
- R4: With ORDER=BURST_LINEAR, each advance cycle reads or writes the next address in the burst. Address bits [1:0] equal the starting bits plus the beat count modulo 4, and the upper bits stay fixed. Each advanced read word appears one cycle after the previous one.
- R5: With ORDER=BURST_INTERLEAVED, address bits [1:0] of each advance cycle equal the starting bits XOR the beat count, and the upper bits stay fixed.
- R6: On a cycle with no strobe and `next_n`=1, and on an advance cycle while no burst is active, no access is made and the read pipeline carries no word. A later advance resumes the burst from the last address it used.
- R7: An access with `wr_all_n`=0 writes all four lanes, whatever `wr_byte_n` and `lane_wr_n` are.
- R8: An access with `wr_all_n`=1 and `wr_byte_n`=0 writes exactly the lanes i (data bits [9i+8:9i]) whose `lane_wr_n[i]` is 0. The other lanes keep their contents.
- R9: An access that enables no lane is a read, and it leaves the array unchanged.
- R10: On a cycle where `strb_cpu_n` is sampled low, the write controls are ignored and the access is a read. This also holds when `strb_ctl_n` is low on the same cycle.
- R11: On a cycle where only `strb_ctl_n` is low, the write controls are honoured at the strobed address.
- R12: With `out_en_n`=1, `rdata_vld` is 0 and `rdata` is all zeros without any clock edge. With `out_en_n`=0, they show the registered read word.
- R13: The address bus is ignored on cycles without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state |
| addr | input | AW | Word address, sampled on strobe edges |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| next_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, zero when not valid |
| rdata_vld | output | 1 | Read data is valid and driven |

## Verification
The bench builds two instances with DEPTH=16: one uses linear order and the other interleaved order, and both are fed the same stimulus. The small depth means random addresses hit the same aligned groups of four again and again. Bursts therefore wrap inside a group, overwrite lanes that were just written, and run into deselecting strobes. Running both orders side by side shows that the only difference between them is the address sequence, while the lane decoding and the latency stay the same.

// File: rtl/sb_pkg.sv
package sb_pkg;

   typedef enum logic {
      BURST_LINEAR      = 1'b0,
      BURST_INTERLEAVED = 1'b1
   } burst_order_e;

   // Registered control set, all active high.
   typedef struct packed {
      logic p_stb;
      logic c_stb;
      logic adv;
      logic sel;
      logic gw;
      logic bwe;
   } ctl_t;

endpackage

// File: rtl/sb_burst_ctr.sv
module sb_burst_ctr
   import sb_pkg::*;
#(
   parameter int           AW    = 6,
   parameter burst_order_e ORDER = BURST_LINEAR
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic          ld_sel,
   input  logic          adv,
   input  logic [AW-1:0] ld_addr,
   output logic          acc,
   output logic [AW-1:0] cur_addr
);

   logic          act_q;
   logic [AW-1:0] base_q;
   logic [1:0]    beat_q;
   logic [1:0]    beat_d;
   logic [1:0]    lo_d;
   logic [AW-1:0] start;

   always_comb begin
      beat_d = beat_q;
      acc    = 1'b0;
      if (ld) begin
         beat_d = 2'd0;
         acc    = ld_sel;
      end else if (adv && act_q) begin
         beat_d = beat_q + 2'd1;
         acc    = 1'b1;
      end
   end

   assign start = ld ? ld_addr : base_q;

   generate
      if (ORDER == BURST_INTERLEAVED) begin : g_il
         assign lo_d = start[1:0] ^ beat_d;
      end else begin : g_lin
         assign lo_d = start[1:0] + beat_d;

         // R4
         lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc && !ld) |-> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));
      end
   endgenerate

   assign cur_addr = {start[AW-1:2], lo_d};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         base_q <= '0;
         beat_q <= 2'd0;
      end else if (ld) begin
         act_q  <= ld_sel;
         base_q <= ld_addr;
         beat_q <= 2'd0;
      end else if (acc) begin
         beat_q <= beat_d;
      end
   end

   // R2
   desel_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !ld_sel) |=> (!acc || ld));

   // R13
   upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ld) |-> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

endmodule

// File: rtl/sb_wr_dec.sv
module sb_wr_dec #(
   parameter int LANES = 4
) (
   input  logic             p_stb,
   input  logic             gw,
   input  logic             bwe,
   input  logic [LANES-1:0] bw,
   output logic [LANES-1:0] lanes
);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lanes[i] = !p_stb && (gw || (bwe && bw[i]));
      end
   endgenerate

endmodule

// File: rtl/sb_array.sv
module sb_array #(
   parameter  int DEPTH  = 64,
   parameter  int LANES  = 4,
   parameter  int LANE_W = 9,
   localparam int AW     = $clog2(DEPTH),
   localparam int DW     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] we,
   input  logic [DW-1:0]    wdata,
   output logic             rd_vld,
   output logic [DW-1:0]    rd_data
);

   logic [DW-1:0] word;
   logic          rd_en;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (acc && we[i]) begin
               mem[addr] <= wdata[i*LANE_W +: LANE_W];
            end
         end

         assign word[i*LANE_W +: LANE_W] = mem[addr];
      end
   endgenerate

   assign rd_en = acc && (we == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld <= 1'b0;
      end else begin
         rd_vld <= rd_en;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) begin
         rd_data <= word;
      end
   end

endmodule

// File: rtl/sb_sram.sv
module sb_sram
   import sb_pkg::*;
#(
   parameter  int           DEPTH  = 64,
   parameter  int           LANES  = 4,
   parameter  int           LANE_W = 9,
   parameter  burst_order_e ORDER  = BURST_LINEAR,
   localparam int           AW     = $clog2(DEPTH),
   localparam int           DW     = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             sel_a_n,
   input  logic             sel_b,
   input  logic             sel_c_n,
   input  logic             strb_cpu_n,
   input  logic             strb_ctl_n,
   input  logic             next_n,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_wr_n,
   input  logic             out_en_n,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   output logic             rdata_vld
);

   initial begin
      depth_param_chk: assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 4");
      lane_param_chk: assert (LANES >= 1 && LANE_W >= 1)
         else $error("LANES and LANE_W must be positive");
   end

   // Input registers
   ctl_t             ctl_q;
   logic [AW-1:0]    addr_q;
   logic [DW-1:0]    wdata_q;
   logic [LANES-1:0] bw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         bw_q    <= '0;
      end else begin
         ctl_q.p_stb <= !strb_cpu_n;
         ctl_q.c_stb <= !strb_ctl_n;
         ctl_q.adv   <= !next_n;
         ctl_q.sel   <= !sel_a_n && sel_b && !sel_c_n;
         ctl_q.gw    <= !wr_all_n;
         ctl_q.bwe   <= !wr_byte_n;
         addr_q      <= addr;
         wdata_q     <= wdata;
         bw_q        <= ~lane_wr_n;
      end
   end

   // Burst address generation
   logic          acc;
   logic [AW-1:0] cur_addr;

   sb_burst_ctr #(
      .AW    (AW),
      .ORDER (ORDER)
   ) i_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ctl_q.p_stb || ctl_q.c_stb),
      .ld_sel   (ctl_q.sel),
      .adv      (ctl_q.adv),
      .ld_addr  (addr_q),
      .acc      (acc),
      .cur_addr (cur_addr)
   );

   // Lane write decode
   logic [LANES-1:0] we_lanes;

   sb_wr_dec #(
      .LANES (LANES)
   ) i_dec (
      .p_stb (ctl_q.p_stb),
      .gw    (ctl_q.gw),
      .bwe   (ctl_q.bwe),
      .bw    (bw_q),
      .lanes (we_lanes)
   );

   // Storage and read stage
   logic          rd_vld;
   logic [DW-1:0] rd_data;

   sb_array #(
      .DEPTH  (DEPTH),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) i_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .addr    (cur_addr),
      .we      (we_lanes),
      .wdata   (wdata_q),
      .rd_vld  (rd_vld),
      .rd_data (rd_data)
   );

   // Output register
   logic          out_vld_q;
   logic [DW-1:0] out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld_q <= 1'b0;
         out_q     <= '0;
      end else begin
         out_vld_q <= rd_vld;
         out_q     <= rd_data;
      end
   end

   assign rdata_vld = out_vld_q && !out_en_n;
   assign rdata     = rdata_vld ? out_q : '0;

   // R10
   p_stb_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && ctl_q.p_stb) |-> (we_lanes == '0));

   // R7
   gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ctl_q.p_stb && ctl_q.gw) |-> (&we_lanes));

   // R3
   read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_q |-> $past(acc && (we_lanes == '0), 2));

   // R12
   oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> (!rdata_vld && (rdata == '0)));

endmodule

// File: tb/test_sb_sram.sv
module test_sb_sram;
   import sb_pkg::*;

   localparam int DEPTH = 16;
   localparam int AW    = 4;
   localparam int DW    = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
   logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, next_n = 1'b1;
   logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
   logic [3:0]    lane_wr_n = 4'hF;
   logic          out_en_n = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata_l, rdata_i;
   logic          vld_l, vld_i;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sb_sram #(.DEPTH(DEPTH), .ORDER(BURST_LINEAR)) i_sb_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
      .sel_c_n(sel_c_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
      .next_n(next_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
      .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .wdata(wdata),
      .rdata(rdata_l), .rdata_vld(vld_l));

   sb_sram #(.DEPTH(DEPTH), .ORDER(BURST_INTERLEAVED)) i_sb_sram_il (
      .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
      .sel_c_n(sel_c_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
      .next_n(next_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
      .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .wdata(wdata),
      .rdata(rdata_i), .rdata_vld(vld_i));

   // Reference state, index 0 linear, index 1 interleaved
   logic [DW-1:0] m_mem [2][DEPTH];
   bit            m_act [2];
   logic [AW-1:0] m_base [2];
   logic [1:0]    m_beat [2];
   bit            ev [2][3];
   logic [DW-1:0] ed [2][3];
   string         etag [3];

   function automatic logic [1:0] burst_lo(input logic [1:0] s, input logic [1:0] b, input int k);
      return (k == 1) ? (s ^ b) : (s + b);
   endfunction

   function automatic logic [3:0] lane_mask();
      if (!strb_cpu_n) return 4'h0;
      if (!wr_all_n) return 4'hF;
      if (!wr_byte_n) return ~lane_wr_n;
      return 4'h0;
   endfunction

   task automatic report(input string tag, input bit av, input logic [DW-1:0] ad,
                         input bit xv, input logic [DW-1:0] xd);
      checks++;
      if (av !== xv || ad !== xd) begin
         errors++;
         $display("FAIL %s: got vld=%0b data=%h, expected vld=%0b data=%h", tag, av, ad, xv, xd);
      end
   endtask

   task automatic check_out();
      for (int k = 0; k < 2; k++) begin
         bit            xv = ev[k][0] && !out_en_n;
         logic [DW-1:0] xd = xv ? ed[k][0] : '0;
         string         t  = etag[0];
         if (t == "BURST") t = (k == 1) ? "R5" : "R4";
         if (k == 0) report(t, vld_l, rdata_l, xv, xd);
         else        report(t, vld_i, rdata_i, xv, xd);
      end
   endtask

   task automatic model_push(input string tag);
      bit strobe = !strb_cpu_n || !strb_ctl_n;
      bit sel    = !sel_a_n && sel_b && !sel_c_n;
      etag[2] = tag;
      for (int k = 0; k < 2; k++) begin
         bit            acc = 1'b0;
         logic [AW-1:0] ad;
         logic [3:0]    ln = lane_mask();
         if (strobe) begin
            m_act[k] = sel;
            if (sel) begin
               m_base[k] = addr;
               m_beat[k] = 2'd0;
               acc = 1'b1;
            end
         end else if (!next_n && m_act[k]) begin
            m_beat[k] = m_beat[k] + 2'd1;
            acc = 1'b1;
         end
         ad = {m_base[k][AW-1:2], burst_lo(m_base[k][1:0], m_beat[k], k)};
         ev[k][2] = 1'b0;
         ed[k][2] = '0;
         if (acc && ln != 4'h0) begin
            for (int i = 0; i < 4; i++)
               if (ln[i]) m_mem[k][ad][i*9 +: 9] = wdata[i*9 +: 9];
         end else if (acc) begin
            ev[k][2] = 1'b1;
            ed[k][2] = m_mem[k][ad];
         end
      end
   endtask

   task automatic drive(input bit sa, input bit sb, input bit sc, input bit cpu, input bit ctl,
                        input bit nx, input bit wa, input bit wb, input logic [3:0] ln,
                        input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      @(negedge clk);
      check_out();
      for (int k = 0; k < 2; k++) begin
         ev[k][0] = ev[k][1]; ed[k][0] = ed[k][1];
         ev[k][1] = ev[k][2]; ed[k][1] = ed[k][2];
      end
      etag[0] = etag[1];
      etag[1] = etag[2];
      sel_a_n = sa; sel_b = sb; sel_c_n = sc;
      strb_cpu_n = cpu; strb_ctl_n = ctl; next_n = nx;
      wr_all_n = wa; wr_byte_n = wb; lane_wr_n = ln;
      addr = a; wdata = d;
      model_push(tag);
   endtask

   task automatic rd_ctl(input logic [AW-1:0] a, input string t);
      drive(0, 1, 0, 1, 0, 1, 1, 1, 4'hF, a, '0, t);
   endtask
   task automatic rd_cpu(input logic [AW-1:0] a, input logic [DW-1:0] d, input string t);
      drive(0, 1, 0, 0, 1, 1, 0, 0, 4'h0, a, d, t);
   endtask
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit wa,
                     input bit wb, input logic [3:0] ln, input string t);
      drive(0, 1, 0, 1, 0, 1, wa, wb, ln, a, d, t);
   endtask
   task automatic adv(input logic [AW-1:0] a, input string t);
      drive(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, a, '0, t);
   endtask
   task automatic idle(input string t);
      drive(0, 1, 0, 1, 1, 1, 1, 1, 4'hF, '0, '0, t);
   endtask

   function automatic logic [DW-1:0] rnd_word();
      return {$urandom, $urandom} & {DW{1'b1}};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, got hung, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int k = 0; k < 2; k++) begin
         m_act[k] = 1'b0; m_base[k] = '0; m_beat[k] = 2'd0;
         for (int s = 0; s < 3; s++) begin ev[k][s] = 1'b0; ed[k][s] = '0; end
      end
      for (int s = 0; s < 3; s++) etag[s] = "R6";

      // R1: reset state
      repeat (3) @(negedge clk);
      report("R1", vld_l, rdata_l, 1'b0, '0);
      report("R1", vld_i, rdata_i, 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      report("R1", vld_l, rdata_l, 1'b0, '0);
      report("R1", vld_i, rdata_i, 1'b0, '0);

      // R11: fill the array through controller-strobed global writes
      for (int a = 0; a < DEPTH; a++)
         wr(a[AW-1:0], rnd_word(), 0, 1, 4'hF, "R11");

      // R3 and bursts from a cpu strobe
      rd_cpu(4'd5, '0, "R3");
      adv(4'd0, "BURST");
      adv(4'd0, "BURST");
      adv(4'd0, "BURST");
      adv(4'd0, "BURST");

      // R7: global write ignores the byte controls
      wr(4'd3, 36'hABCDE1234, 0, 1, 4'hF, "R7");
      wr(4'd2, 36'h123456789, 0, 0, 4'hE, "R7");
      rd_ctl(4'd3, "R7");
      rd_ctl(4'd2, "R7");

      // R8: byte write of lanes 0 and 2 only
      wr(4'd3, 36'h5A5A5A5A5, 1, 0, 4'b1010, "R8");
      rd_ctl(4'd3, "R8");

      // R9: no lanes enabled is a read
      wr(4'd3, 36'hFFFFFFFFF, 1, 0, 4'hF, "R9");
      rd_ctl(4'd3, "R9");

      // R10: cpu strobe ignores a global write, also with both strobes low
      rd_cpu(4'd3, 36'h000111222, "R10");
      drive(0, 1, 0, 0, 0, 1, 0, 1, 4'h0, 4'd3, 36'h333444555, "R10");
      rd_ctl(4'd3, "R10");

      // R2: deselecting strobes end the burst
      rd_ctl(4'd4, "R2");
      drive(0, 0, 0, 1, 0, 1, 1, 1, 4'hF, 4'd4, '0, "R2");
      adv(4'd0, "R2");
      rd_ctl(4'd4, "R2");
      drive(1, 1, 0, 0, 1, 1, 1, 1, 4'hF, 4'd4, '0, "R2");
      adv(4'd0, "R2");
      drive(0, 1, 1, 1, 0, 1, 1, 1, 4'hF, 4'd4, '0, "R2");
      adv(4'd0, "R2");

      // R6: suspension and resume, advance without burst
      rd_ctl(4'd8, "R3");
      idle("R6");
      adv(4'd0, "R6");
      idle("R6");
      adv(4'd0, "R6");

      // R13: address bus changes during advances are ignored
      rd_ctl(4'd14, "R13");
      adv(4'd1, "R13");
      adv(4'd6, "R13");
      adv(4'd9, "R13");

      // R12: asynchronous output enable
      wr(4'd6, 36'h0F0F0F0F0, 0, 1, 4'hF, "R12");
      rd_ctl(4'd6, "R12");
      idle("R12");
      idle("R12");
      idle("R12");
      out_en_n = 1'b1;
      #1;
      report("R12", vld_l, rdata_l, 1'b0, '0);
      report("R12", vld_i, rdata_i, 1'b0, '0);
      out_en_n = 1'b0;
      #1;
      report("R12", vld_l, rdata_l, 1'b1, 36'h0F0F0F0F0);
      report("R12", vld_i, rdata_i, 1'b1, 36'h0F0F0F0F0);

      // Random mix
      for (int n = 0; n < 4000; n++) begin
         int            r  = $urandom % 8;
         bit            ds = ($urandom % 8) == 0;
         logic [AW-1:0] a  = $urandom % DEPTH;
         bit            wa = ($urandom % 4) != 0;
         bit            wb = ($urandom % 2) != 0;
         logic [3:0]    ln = $urandom % 16;
         out_en_n = ($urandom % 16) == 0;
         if (r < 2)
            drive(0, !ds, 0, 1, 0, 1, wa, wb, ln, a, rnd_word(), (wa && wb) ? "R3" : "R11");
         else if (r == 2)
            drive(ds, 1, 0, 0, $urandom % 2, 1, wa, wb, ln, a, rnd_word(), "R10");
         else if (r < 7)
            drive(0, 1, 0, 1, 1, 0, wa, wb, ln, a, rnd_word(), "BURST");
         else
            drive(0, 1, 0, 1, 1, 1, wa, wb, ln, a, rnd_word(), "R6");
      end
      out_en_n = 1'b0;
      repeat (4) idle("R6");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule